// File: doc/BRIEF.md
# Co-processor Status Register with Paired Clear/Set Commands

This block holds the run-control and software flags of a co-processor. Software never writes the status value directly. It writes a command word instead, and each controllable flag has one command bit that clears it and another that sets it. The flags are halt, broke, single-step, interrupt-on-break and eight software signal flags. The same command word can also ask the interrupt controller to raise or drop the co-processor's interrupt line. The block sends these requests out as one-cycle pulses.

Each accepted command can release the co-processor from halt or from a break. The block then decides whether the co-processor should start, and emits a one-cycle start pulse when it should. A separate break input from the core sets the broke flag. When interrupt-on-break is enabled, that input also raises an interrupt request. All outputs are registered and change on the clock edge that samples the command.

Top module: `cop_status_ctrl`

## Requirements
- R1: After reset, status bit 0 (halt) is 1, every other status bit is 0, and irq_set_req, irq_clr_req and start_task are 0.
- R2: Command bit 0 clears halt (status bit 0) and command bit 1 sets it.
- R3: Command bit 2 clears broke (status bit 1). No command bit sets broke. A break_evt cycle sets broke, and this wins over a clear given in the same cycle.
- R4: Command bits 5 and 6 clear and set single-step (status bit 5). Command bits 7 and 8 clear and set interrupt-on-break (status bit 6).
- R5: Signal flag n (n = 0..7) sits at status bit 7+n. Command bit 9+2n clears it and command bit 10+2n sets it.
- R6: When the clear and set bits of one pair are both 1, the flag ends up set.
- R7: Command bit 3 gives a one-cycle irq_clr_req pulse and command bit 4 gives a one-cycle irq_set_req pulse, in the cycle after the command.
- R8: A break_evt cycle gives an irq_set_req pulse in the next cycle when interrupt-on-break was 1 before that edge. It gives no pulse when interrupt-on-break was 0.
- R9: start_task pulses for one cycle after a command only if command bit 0 or command bit 2 was 1 and, after the update, halt and broke are both 0.
- R10: Status bits 2 to 4 and 15 to 31 always read 0, and command bits 25 to 31 have no effect.
- R11: A command takes effect on the edge where cmd_valid is sampled high. With cmd_valid low the command word has no effect on status or on the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 32 | Paired clear/set command bits |
| break_evt | input | 1 | Break event from the co-processor core |
| status_q | output | 32 | Current status value |
| irq_set_req | output | 1 | One-cycle request to raise the interrupt |
| irq_clr_req | output | 1 | One-cycle request to drop the interrupt |
| start_task | output | 1 | One-cycle request to start the co-processor |

## Verification
A wrong flag register shows up on status_q one cycle after the command that touched it. A wrong pair decode sends the wrong bit position to status_q in that same cycle. A faulty start decision shows in the same cycle as a start_task pulse that disagrees with the halt and broke bits visible beside it. A faulty interrupt decision shows the same way on the request pulses. Every state error is therefore visible at the ports after one edge. The bench then compares every output against an arithmetic model after each command.

// File: rtl/cop_status_pkg.sv
package cop_status_pkg;
  localparam int CMD_W   = 32;
  localparam int STAT_W  = 32;
  localparam int FIX_FLG = 4;               // halt, broke, single-step, int-on-break
  localparam int IDX_HALT  = 0;
  localparam int IDX_BROKE = 1;
  localparam int IDX_SSTEP = 2;
  localparam int IDX_IBRK  = 3;
  localparam int CMD_IRQ_CLR = 3;
  localparam int CMD_IRQ_SET = 4;

  // status bit position of flag index i
  function automatic int flag_pos(input int i);
    return (i < 2) ? i : i + 3;
  endfunction

  // command bit that clears flag index i
  function automatic int clr_bit(input int i);
    if (i == IDX_HALT)  return 0;
    if (i == IDX_BROKE) return 2;
    return 2 * i + 1;
  endfunction

  // command bit that sets flag index i (-1: no set bit)
  function automatic int set_bit(input int i);
    if (i == IDX_HALT)  return 1;
    if (i == IDX_BROKE) return -1;
    return 2 * i + 2;
  endfunction

  // clear first, then set
  function automatic logic pair_apply(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic may_start(input logic wake, input logic halt_n, input logic broke_n);
    return wake & ~halt_n & ~broke_n;
  endfunction
endpackage

// File: rtl/cop_cmd_decode.sv
module cop_cmd_decode
  import cop_status_pkg::*;
#(
  parameter int NUM_SIG = 8,
  localparam int NFLAG = FIX_FLG + NUM_SIG
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] set_vec,
  output logic             irq_clr_hit,
  output logic             irq_set_hit,
  output logic             wake_hit
);
  // every command bit is scanned; bits with no target fall through (R10)
  always_comb begin
    clr_vec     = '0;
    set_vec     = '0;
    irq_clr_hit = 1'b0;
    irq_set_hit = 1'b0;
    for (int b = 0; b < CMD_W; b++) begin
      for (int i = 0; i < NFLAG; i++) begin
        if (b == clr_bit(i)) clr_vec[i] = clr_vec[i] | (cmd_valid & cmd_word[b]);
        if (b == set_bit(i)) set_vec[i] = set_vec[i] | (cmd_valid & cmd_word[b]);
      end
      if (b == CMD_IRQ_CLR) irq_clr_hit = cmd_valid & cmd_word[b];
      if (b == CMD_IRQ_SET) irq_set_hit = cmd_valid & cmd_word[b];
    end
    wake_hit = clr_vec[IDX_HALT] | clr_vec[IDX_BROKE];
  end
endmodule

// File: rtl/cop_flag_bank.sv
module cop_flag_bank
  import cop_status_pkg::*;
#(
  parameter int NFLAG = 12,
  parameter logic [NFLAG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic [NFLAG-1:0] set_vec,
  output logic [NFLAG-1:0] flags_d,
  output logic [NFLAG-1:0] flags_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flags_d[i] = pair_apply(flags_q[i], clr_vec[i], set_vec[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[i] <= RST_VAL[i];
      else        flags_q[i] <= flags_d[i];
    end

    // R6: a set request always leaves the flag set
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_q[i]);
    // R2: a lone clear leaves the flag cleared
    assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
  end
endmodule

// File: rtl/cop_pulse_gen.sv
module cop_pulse_gen
  import cop_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake_hit,
  input  logic halt_next,
  input  logic broke_next,
  input  logic irq_clr_hit,
  input  logic irq_set_hit,
  input  logic break_evt,
  input  logic ibrk_now,
  output logic irq_set_req,
  output logic irq_clr_req,
  output logic start_task
);
  logic brk_irq;
  assign brk_irq = break_evt & ibrk_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_set_req <= 1'b0;
      irq_clr_req <= 1'b0;
      start_task  <= 1'b0;
    end else begin
      irq_set_req <= irq_set_hit | brk_irq;
      irq_clr_req <= irq_clr_hit;
      start_task  <= may_start(wake_hit, halt_next, broke_next);
    end
  end

  // R7: clear request pulse follows its command bit one cycle later
  assert_irq_clr_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_hit |=> irq_clr_req);
  // R8: break with interrupt-on-break enabled raises the set request
  assert_brk_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> irq_set_req);
  // R9: no start without a halt or broke clear
  assert_start_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_hit |=> !start_task);
endmodule

// File: rtl/cop_status_ctrl.sv
module cop_status_ctrl
  import cop_status_pkg::*;
#(
  parameter int NUM_SIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              break_evt,
  output logic [STAT_W-1:0] status_q,
  output logic              irq_set_req,
  output logic              irq_clr_req,
  output logic              start_task
);
  localparam int NFLAG = FIX_FLG + NUM_SIG;
  localparam logic [NFLAG-1:0] RST_FLAGS = NFLAG'(1) << IDX_HALT;

  logic [NFLAG-1:0] clr_vec, set_cmd, set_vec;
  logic [NFLAG-1:0] flags_d, flags_q;
  logic             irq_clr_hit, irq_set_hit, wake_hit;

  cop_cmd_decode #(.NUM_SIG(NUM_SIG)) u_dec (
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .clr_vec     (clr_vec),
    .set_vec     (set_cmd),
    .irq_clr_hit (irq_clr_hit),
    .irq_set_hit (irq_set_hit),
    .wake_hit    (wake_hit)
  );

  // broke is set only by the core's break event (R3)
  always_comb begin
    set_vec            = set_cmd;
    set_vec[IDX_BROKE] = break_evt;
  end

  cop_flag_bank #(.NFLAG(NFLAG), .RST_VAL(RST_FLAGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_vec (clr_vec),
    .set_vec (set_vec),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  cop_pulse_gen u_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_hit    (wake_hit),
    .halt_next   (flags_d[IDX_HALT]),
    .broke_next  (flags_d[IDX_BROKE]),
    .irq_clr_hit (irq_clr_hit),
    .irq_set_hit (irq_set_hit),
    .break_evt   (break_evt),
    .ibrk_now    (flags_q[IDX_IBRK]),
    .irq_set_req (irq_set_req),
    .irq_clr_req (irq_clr_req),
    .start_task  (start_task)
  );

  // place flags at their status positions; the rest reads zero (R10)
  always_comb begin
    status_q = '0;
    for (int i = 0; i < NFLAG; i++) status_q[flag_pos(i)] = flags_q[i];
  end

  // R9: a start is only issued when the core is neither halted nor broken
  assert_start_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_task |-> (!status_q[0] && !status_q[1]));
  // R3: broke only rises after a break event
  assert_broke_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[1]) |-> $past(break_evt));
  // R10: unused status positions stay zero
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[4:2] == 3'b0) && (status_q[STAT_W-1:flag_pos(NFLAG-1)+1] == '0));
  // R11: with no command and no break, status holds
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !break_evt) |=> $stable(status_q));
endmodule

// File: tb/sim_cop_status_ctrl.sv
module sim_cop_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        break_evt = 1'b0;
  logic [31:0] status_q;
  logic        irq_set_req, irq_clr_req, start_task;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [31:0] ms;        // model status
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;  // 50 MHz

  cop_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .break_evt(break_evt), .status_q(status_q), .irq_set_req(irq_set_req),
    .irq_clr_req(irq_clr_req), .start_task(start_task)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model written as a list of explicit rules
  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] c, input logic b);
    logic [31:0] r = s;
    if (c[0]) r[0] = 1'b0;
    if (c[1]) r[0] = 1'b1;
    if (c[2]) r[1] = 1'b0;
    if (b)    r[1] = 1'b1;
    if (c[5]) r[5] = 1'b0;
    if (c[6]) r[5] = 1'b1;
    if (c[7]) r[6] = 1'b0;
    if (c[8]) r[6] = 1'b1;
    for (int n = 0; n < 8; n++) begin
      if (c[9 + 2*n])  r[7 + n] = 1'b0;
      if (c[10 + 2*n]) r[7 + n] = 1'b1;
    end
    return r;
  endfunction

  // drive one cycle at negedge, check after the sampling edge
  task automatic step(input logic v, input logic [31:0] c, input logic b, input string req);
    logic [31:0] ce, ns;
    logic es, ec, et;
    ce = v ? c : 32'h0;
    ns = model(ms, ce, b);
    es = ce[4] | (b & ms[6]);
    ec = ce[3];
    et = (ce[0] | ce[2]) & ~ns[0] & ~ns[1];
    @(negedge clk);
    cmd_valid = v; cmd_word = c; break_evt = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = 32'h0; break_evt = 1'b0;
    chk({req, " status"},    status_q,           ns);
    chk({req, " irq_set"},   {31'b0, irq_set_req}, {31'b0, es});
    chk({req, " irq_clr"},   {31'b0, irq_clr_req}, {31'b0, ec});
    chk({req, " start"},     {31'b0, start_task},  {31'b0, et});
    ms = ns;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    ms = 32'h1;
    chk("R1 status", status_q, 32'h1);
    chk("R1 pulses", {29'b0, irq_set_req, irq_clr_req, start_task}, 32'h0);

    // R2 R3 R4 R5 R7 R10: every single command bit from the evolving state
    for (int b = 0; b < 32; b++) step(1'b1, 32'h1 << b, 1'b0, "R2 R4 R5 R7 R10 single");
    for (int b = 31; b >= 0; b--) step(1'b1, 32'h1 << b, 1'b0, "R10 single down");

    // R6: both bits of every pair, from set and cleared states
    for (int i = 0; i < 12; i++) begin
      int cb = (i == 0) ? 0 : (i == 1) ? 2 : 2*i + 1;
      int sb = (i == 0) ? 1 : 2*i + 2;
      step(1'b1, 32'h1 << cb, 1'b0, "R6 pre-clear");
      if (i != 1) step(1'b1, (32'h1 << cb) | (32'h1 << sb), 1'b0, "R6 both");
      if (i != 1) step(1'b1, (32'h1 << cb) | (32'h1 << sb), 1'b0, "R6 both again");
    end

    // R3 R8: break with interrupt-on-break off, then on, then with a same-cycle clear
    step(1'b1, 32'h0000_0080, 1'b0, "R8 ibrk off");
    step(1'b0, 32'h0, 1'b1, "R8 break no irq");
    step(1'b1, 32'h0000_0100, 1'b0, "R8 ibrk on");
    step(1'b0, 32'h0, 1'b1, "R8 break irq");
    step(1'b1, 32'h0000_0005, 1'b1, "R3 break beats clear");
    // R9: release halt and broke, then a clear that keeps halt
    step(1'b1, 32'h0000_0005, 1'b0, "R9 start");
    step(1'b1, 32'h0000_0003, 1'b0, "R9 clear+set halt no start");
    step(1'b1, 32'h0000_0001, 1'b0, "R9 start halt only");
    step(1'b1, 32'h0000_0040, 1'b0, "R9 no wake bit");

    // R11: garbage with cmd_valid low
    step(1'b0, 32'hFFFF_FFFF, 1'b0, "R11 invalid all ones");
    step(1'b0, 32'h0155_5555, 1'b0, "R11 invalid pattern");

    // mixed patterns, occasional break
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[27] | lfsr[13], lfsr, (lfsr[5:2] == 4'h0), "R9 R11 mixed");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule